// File: doc/BRIEF.md
# Digital Microphone Clock and Capture Strobe Generator

This block derives the bit clock for pulse-density-modulated microphones from the system clock, using an integer divider. For a divider N, the clock stays high for floor(N/2) system cycles and low for the rest of the period, so odd dividers still give a duty cycle close to one half. The clock only runs while at least one of the two microphones is enabled. While both are off it is held low, and it always restarts at the start of a high phase.

Next to the clock, the block produces one capture strobe per microphone. A strobe is a single-cycle pulse that marks when that microphone's data bit should be sampled. It is taken from either the rising or the falling clock edge and then delayed by a programmable number of system cycles to absorb board and microphone delay. A divider that would put the microphone clock below 100 kHz for the configured system clock frequency is reported as invalid. Decimation of the captured bits is done elsewhere.

Top module: `pdm_clkgen`

## Requirements
- R1: With an effective divider N, the clock repeats every N system cycles. Each period is floor(N/2) high cycles followed by N - floor(N/2) low cycles.
- R2: A divider value of 0 or 1 behaves exactly like a divider of 2.
- R3: `pdmClk` and both strobes are low during reset. They are also low in every cycle that follows a clock edge at which both enables were low.
- R4: The first clock edge at which either enable is sampled high drives `pdmClk` high and starts a full high phase.
- R5: With `edgeSel` = 0, a strobe rises `skewVal` system cycles after the cycle in which `pdmClk` rose. `skewVal` = 0 puts the strobe in the same cycle as the rise. Skews longer than a clock period are allowed and overlap correctly.
- R6: With `edgeSel` = 1, the strobes count the skew from the cycle in which `pdmClk` fell instead.
- R7: `strobeA` is gated by `enA` alone and `strobeB` by `enB` alone. The clock runs when either enable is high.
- R8: `divInvalid` is high exactly when the effective divider exceeds SYS_CLK_HZ / MIN_PDM_HZ, which is 240 with the defaults of 24 MHz and 100 kHz.
- R9: An odd divider gives the shorter phase to the high level. For example, 5 gives 2 high and 3 low, and 7 gives 3 high and 4 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divVal | input | 8 | Clock divider; 0 and 1 are treated as 2 |
| skewVal | input | 4 | Strobe delay after the selected edge, in system cycles |
| edgeSel | input | 1 | 0: capture from the rising edge, 1: from the falling edge |
| enA | input | 1 | Enable for microphone A |
| enB | input | 1 | Enable for microphone B |
| pdmClk | output | 1 | Microphone clock |
| strobeA | output | 1 | Capture strobe for microphone A |
| strobeB | output | 1 | Capture strobe for microphone B |
| divInvalid | output | 1 | Divider gives a clock below the minimum frequency |

## Verification
The hardest situation to reach from the ports is a skew longer than the clock period. In that case several strobe events are in flight in the delay line at once, and a turn-off has to flush them. The stimulus uses a divider of 2 with a skew of 5, and a divider of 6 with a skew of 15 on the falling edge. Each run ends by dropping both enables, and the next run starts right after. Any strobe left over from the previous run would then show up as an unexpected pulse in the scoreboard.

// File: rtl/pdm_clk_pkg.sv
package pdm_clk_pkg;
  // Single-cycle markers raised in the same cycle as the clock output changes.
  typedef struct packed {
    logic rise;
    logic fall;
  } pdmEdge_t;
endpackage

// File: rtl/pdm_clk_ctrl.sv
module pdm_clk_ctrl
  import pdm_clk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int MAX_DIV = 240
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  logic             run,
  output logic             pdmClk,
  output pdmEdge_t         edges,
  output logic             divTooSlow
);
  localparam logic [DIV_W-1:0] MinDiv = DIV_W'(2);

  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] hiLen;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cntNext;
  logic             active;
  logic             clkNext;

  always_comb begin
    effDiv     = (divVal < MinDiv) ? MinDiv : divVal;
    hiLen      = effDiv >> 1;
    cntNext    = (!active || cnt >= effDiv - 1'b1) ? '0 : cnt + 1'b1;
    clkNext    = cntNext < hiLen;
    divTooSlow = int'(effDiv) > MAX_DIV;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      active <= 1'b0;
      cnt    <= '0;
      pdmClk <= 1'b0;
      edges  <= '0;
    end else begin
      active     <= 1'b1;
      cnt        <= cntNext;
      pdmClk     <= clkNext;
      edges.rise <= clkNext & ~pdmClk;
      edges.fall <= ~clkNext & pdmClk;
    end
  end
endmodule

// File: rtl/pdm_strobe_path.sv
module pdm_strobe_path
  import pdm_clk_pkg::*;
#(
  parameter int SKEW_W   = 4,
  parameter int NUM_MICS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                run,
  input  pdmEdge_t            edges,
  input  logic                edgeSel,
  input  logic [SKEW_W-1:0]   skewVal,
  input  logic [NUM_MICS-1:0] micEn,
  output logic [NUM_MICS-1:0] micStrobe
);
  localparam int Depth = 1 << SKEW_W;

  logic             evt;
  logic [Depth-2:0] dlyReg;
  logic [Depth-1:0] tapVec;
  logic             tap;

  assign evt    = edgeSel ? edges.fall : edges.rise;
  assign tapVec = {dlyReg, evt};
  assign tap    = tapVec[skewVal];

  // Flushing on stop keeps stale events out of the next run.
  always_ff @(posedge clk) begin
    if (!rstN || !run) dlyReg <= '0;
    else               dlyReg <= {dlyReg[Depth-3:0], evt};
  end

  for (genvar m = 0; m < NUM_MICS; m++) begin : g_mic
    assign micStrobe[m] = tap & micEn[m];
  end
endmodule

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
  import pdm_clk_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int SKEW_W     = 4,
  parameter int SYS_CLK_HZ = 24_000_000,
  parameter int MIN_PDM_HZ = 100_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [SKEW_W-1:0] skewVal,
  input  logic              edgeSel,
  input  logic              enA,
  input  logic              enB,
  output logic              pdmClk,
  output logic              strobeA,
  output logic              strobeB,
  output logic              divInvalid
);
  localparam int MaxDiv = SYS_CLK_HZ / MIN_PDM_HZ;

  pdmEdge_t   edges;
  logic       run;
  logic [1:0] micStrobe;

  assign run = enA | enB;

  pdm_clk_ctrl #(.DIV_W(DIV_W), .MAX_DIV(MaxDiv)) u_ctrl (
    .clk(clk), .rstN(rstN), .divVal(divVal), .run(run),
    .pdmClk(pdmClk), .edges(edges), .divTooSlow(divInvalid)
  );

  pdm_strobe_path #(.SKEW_W(SKEW_W), .NUM_MICS(2)) u_strobe (
    .clk(clk), .rstN(rstN), .run(run), .edges(edges), .edgeSel(edgeSel),
    .skewVal(skewVal), .micEn({enB, enA}), .micStrobe(micStrobe)
  );

  assign strobeA = micStrobe[0];
  assign strobeB = micStrobe[1];
endmodule

// File: rtl/pdm_clkgen_chk.sv
module pdm_clkgen_chk #(
  parameter int DIV_W  = 8,
  parameter int SKEW_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [DIV_W-1:0]  divVal,
  input logic [SKEW_W-1:0] skewVal,
  input logic              edgeSel,
  input logic              enA,
  input logic              enB,
  input logic              pdmClk,
  input logic              strobeA,
  input logic              strobeB,
  input logic              divInvalid
);
  logic [DIV_W:0]   hiCnt;
  logic [DIV_W-1:0] prevDiv;
  logic             divChg;
  logic [DIV_W-1:0] expHi;

  assign expHi = ((divVal < DIV_W'(2)) ? DIV_W'(2) : divVal) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt   <= '0;
      prevDiv <= '0;
      divChg  <= 1'b0;
    end else begin
      hiCnt   <= pdmClk ? hiCnt + 1'b1 : '0;
      prevDiv <= divVal;
      if (!pdmClk)                divChg <= 1'b0;
      else if (divVal != prevDiv) divChg <= 1'b1;
    end
  end

  // R1 R9
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pdmClk) && (enA || enB) && $past(enA || enB) && !divChg && divVal == prevDiv)
      |-> hiCnt == {1'b0, expHi});

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!(enA || enB)) |-> !pdmClk);

  // R3
  strobe_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!(enA || enB)) |-> (!strobeA && !strobeB));

  // R4
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdmClk) |-> $past(enA || enB));

  // R5
  zero_skew_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skewVal == '0 && !edgeSel && strobeA) |-> $rose(pdmClk));
endmodule

bind pdm_clkgen pdm_clkgen_chk #(.DIV_W(DIV_W), .SKEW_W(SKEW_W)) u_chk (.*);

// File: tb/sim_pdm_clkgen.sv
module sim_pdm_clkgen;
  typedef struct {
    int    due;
    bit    expClk;
    bit    expA;
    bit    expB;
    string req;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divVal = 8'd4;
  logic [3:0] skewVal = 4'd0;
  logic       edgeSel = 1'b0;
  logic       enA = 1'b0;
  logic       enB = 1'b0;
  logic       pdmClk, strobeA, strobeB, divInvalid;

  int    cyc = 0;
  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  item_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  pdm_clkgen u0 (
    .clk(clk), .rstN(rstN), .divVal(divVal), .skewVal(skewVal), .edgeSel(edgeSel),
    .enA(enA), .enB(enB), .pdmClk(pdmClk), .strobeA(strobeA), .strobeB(strobeB),
    .divInvalid(divInvalid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares every due item against the outputs.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.due != cyc || pdmClk !== it.expClk || strobeA !== it.expA || strobeB !== it.expB) begin
        errors++;
        $display("FAIL %s cyc=%0d: clk/A/B actual %b%b%b expected %b%b%b", it.req, cyc,
                 pdmClk, strobeA, strobeB, it.expClk, it.expA, it.expB);
      end
    end
  end

  function automatic bit hit(int k, int eff, int hi, int s, bit fallEdge);
    int off;
    off = fallEdge ? s + hi : s;
    return (k >= off) && (((k - off) % eff) == 0);
  endfunction

  task automatic runCase(int dv, int sk, bit es, bit a, bit b, int n, string tag);
    int eff, hi, base;
    @(negedge clk); #1;
    divVal = 8'(dv); skewVal = 4'(sk); edgeSel = es; enA = a; enB = b;
    eff  = (dv < 2) ? 2 : dv;
    hi   = eff / 2;
    base = cyc;
    for (int k = 0; k < n; k++) begin
      item_t it;
      bit h;
      h = hit(k, eff, hi, sk, es);
      it.due = base + 1 + k; it.expClk = (k % eff) < hi;
      it.expA = a && h; it.expB = b && h;
      it.req = (k == 0) ? "R4" : tag;
      q.push_back(it);
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic stopAll(int n);
    int base;
    @(negedge clk); #1;
    enA = 1'b0; enB = 1'b0;
    base = cyc;
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.due = base + 1 + k; it.expClk = 1'b0; it.expA = 1'b0; it.expB = 1'b0;
      it.req = "R3";
      q.push_back(it);
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic checkInvalid(int dv, bit exp);
    @(negedge clk); #1;
    divVal = 8'(dv);
    #0.5;
    checks++;
    if (divInvalid !== exp) begin
      errors++;
      $display("FAIL R8 div=%0d: divInvalid actual %b expected %b", dv, divInvalid, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (pdmClk !== 1'b0 || strobeA !== 1'b0 || strobeB !== 1'b0) begin
      errors++;
      $display("FAIL R3 reset: clk/A/B actual %b%b%b expected 000", pdmClk, strobeA, strobeB);
    end
    rstN = 1'b1;
    stopAll(4);
    runCase(4, 0, 0, 1, 1, 24, "R1");   stopAll(5);
    runCase(5, 0, 0, 1, 1, 25, "R9");   stopAll(5);
    runCase(7, 3, 1, 1, 1, 30, "R6");   stopAll(5);
    runCase(0, 0, 0, 1, 1, 12, "R2");   stopAll(5);
    runCase(1, 1, 1, 1, 1, 12, "R2");   stopAll(5);
    runCase(3, 2, 0, 1, 0, 18, "R7");   stopAll(5);
    runCase(6, 1, 1, 0, 1, 18, "R7");   stopAll(5);
    runCase(2, 5, 0, 0, 1, 16, "R5");   stopAll(5);
    runCase(6, 15, 1, 1, 1, 40, "R5");  stopAll(5);
    runCase(2, 15, 0, 1, 1, 8, "R5");   stopAll(20);
    checkInvalid(240, 1'b0);
    checkInvalid(241, 1'b1);
    checkInvalid(255, 1'b1);
    checkInvalid(0, 1'b0);
    checkInvalid(2, 1'b0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule